// File: doc/BRIEF.md
# Dual-Queue Double-Pumped Micro-Op Scheduler

This block sits between register renaming and the execution units of an out-of-order core. Each clock it can accept up to three renamed micro-ops. It sends each one to one of two queues. Memory operations (loads and stores) go to a memory queue. Everything else goes to an integer/floating-point queue. Each queue holds eight entries in age order.

The integer/floating-point queue feeds two issue ports. Each port runs twice per clock, so a clock is modelled as an early sub-slot and a late sub-slot. The unit bindings differ between the two ports and between the two sub-slots:

- In the early sub-slot, port 0 can serve a fast ALU or the floating-point move unit.
- In the early sub-slot, port 1 can serve a fast ALU, the shift/rotate ALU or the floating-point execute unit.
- In the late sub-slot, each port serves only its fast ALU.

The memory queue has one load port and one store port. A global writeback budget caps the total number of issues in any clock. A uop that is not ready waits in its queue until a wake-up broadcast carrying its tag arrives.

The issue outputs are computed from the registered queue contents. A uop written into a queue at a clock edge can therefore appear on an issue slot during the following cycle. It leaves its queue at the edge that ends that cycle.

Top module: `dual_uop_scheduler`

## Requirements
- R1: Up to three input uops are taken per clock. Input lane 0 is the oldest and lane 2 the youngest. The unit-class field is 3 bits wide, with these codes:
  - 0: fast ALU
  - 1: shift/rotate
  - 2: FP move
  - 3: FP execute
  - 4: load
  - 5: store

  Codes 4 and 5 enter the memory queue. All other codes enter the integer/FP queue.
- R2: Issue slot 0 is port 0 in the early sub-slot and carries only class 0 or 2. Slot 2 is port 0 in the late sub-slot and carries only class 0.
- R3: Issue slot 1 is port 1 in the early sub-slot and carries only class 1, 3 or 0. Slot 3 is port 1 in the late sub-slot and carries only class 0.
- R4: For each slot, the oldest ready uop whose class the slot accepts is chosen. A uop already taken by an earlier slot in the same clock is not chosen again.
- R5: Slots are filled in the order 0, 1, 2, 3. A fast-ALU uop therefore goes to port 0 before port 1 may take one.
- R6: Slot 4 issues at most one load per clock and slot 5 at most one store per clock. Each takes the oldest ready uop of its kind.
- R7: At most three uops issue per clock. When more are eligible, the earliest slots in the order 0 to 5 issue. The rest stay queued for a later clock.
- R8: Each queue holds 8 uops. `in_accept` is high only when both queues can take every valid input bound to them, given their occupancy at the start of the clock. When it is low, no input uop enters either queue.
- R9: A uop that enters with its ready bit low never issues until a `wake_vld` pulse with a matching tag has been registered.
- R10: After reset both queues are empty, no slot issues, and `in_accept` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld | input | 3 | Per-lane valid for incoming uops |
| in_rdy | input | 3 | Per-lane ready bit of incoming uops |
| in_cls | input | 9 | Per-lane unit class, 3 bits per lane |
| in_tag | input | 18 | Per-lane tag, 6 bits per lane |
| in_accept | output | 1 | All valid lanes are taken this clock |
| wake_vld | input | 1 | Wake-up broadcast valid |
| wake_tag | input | 6 | Tag being woken |
| iss_vld | output | 6 | Issue valid per slot (0,1 early; 2,3 late; 4 load; 5 store) |
| iss_cls | output | 18 | Class of the uop on each slot, 3 bits per slot |
| iss_tag | output | 36 | Tag of the uop on each slot, 6 bits per slot |

## Verification
A fault in the queue compaction would show up in the first cycle after the fault. A uop would be dropped, duplicated or issued out of age order, and it would appear on the issue slots at once. The drain sequences check every tag and slot position.

A miscounted occupancy would show at `in_accept` in the clock the queue reaches eight entries. A uop lost there becomes visible when the queue drains to empty with fewer issues than pushes.

Errors in slot binding or in the writeback cap show up in the issue-valid pattern of the very cycle in which more uops are eligible than can issue.

// File: rtl/uop_sched_pkg.sv
package uop_sched_pkg;

  typedef enum logic [2:0] {
    CLS_FAST  = 3'd0,
    CLS_SHIFT = 3'd1,
    CLS_FPMOV = 3'd2,
    CLS_FPEXE = 3'd3,
    CLS_LOAD  = 3'd4,
    CLS_STORE = 3'd5
  } ucls_e;

  localparam int CLS_W  = 3;
  localparam int NCLS   = 8;
  localparam int NSLOT  = 6;
  localparam int NALU_S = 4;

  function automatic logic [NCLS-1:0] slot_allow(input int s);
    logic [NCLS-1:0] m;
    m = '0;
    m[CLS_FAST] = 1'b1;
    case (s)
      0: m[CLS_FPMOV] = 1'b1;
      1: begin
        m[CLS_SHIFT] = 1'b1;
        m[CLS_FPEXE] = 1'b1;
      end
      4: m = NCLS'(1) << CLS_LOAD;
      5: m = NCLS'(1) << CLS_STORE;
      default: ;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/uop_queue.sv
module uop_queue
  import uop_sched_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAG_W = 6,
  parameter int NIN   = 3,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIN-1:0]    enq_vld,
  input  logic [NIN-1:0]    enq_rdy,
  input  ucls_e             enq_cls [NIN],
  input  logic [TAG_W-1:0]  enq_tag [NIN],
  input  logic [DEPTH-1:0]  deq,
  input  logic              wake_vld,
  input  logic [TAG_W-1:0]  wake_tag,
  output logic [DEPTH-1:0]  q_vld,
  output logic [DEPTH-1:0]  q_rdy,
  output ucls_e             q_cls [DEPTH],
  output logic [TAG_W-1:0]  q_tag [DEPTH],
  output logic [CNT_W-1:0]  count
);

  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [DEPTH-1:0] n_vld, n_rdy;
  ucls_e            n_cls [DEPTH];
  logic [TAG_W-1:0] n_tag [DEPTH];
  logic [CNT_W-1:0] wr;
  logic             upd;

  // survivors shift toward index 0 in age order, then new uops append
  always_comb begin
    n_vld = '0;
    n_rdy = '0;
    for (int i = 0; i < DEPTH; i++) begin
      n_cls[i] = CLS_FAST;
      n_tag[i] = '0;
    end
    wr = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (q_vld[i] && !deq[i]) begin
        n_vld[wr[IDX_W-1:0]] = 1'b1;
        n_rdy[wr[IDX_W-1:0]] = q_rdy[i] | (wake_vld && (wake_tag == q_tag[i]));
        n_cls[wr[IDX_W-1:0]] = q_cls[i];
        n_tag[wr[IDX_W-1:0]] = q_tag[i];
        wr = wr + 1'b1;
      end
    end
    for (int j = 0; j < NIN; j++) begin
      if (enq_vld[j] && (wr < DEPTH_C)) begin
        n_vld[wr[IDX_W-1:0]] = 1'b1;
        n_rdy[wr[IDX_W-1:0]] = enq_rdy[j];
        n_cls[wr[IDX_W-1:0]] = enq_cls[j];
        n_tag[wr[IDX_W-1:0]] = enq_tag[j];
        wr = wr + 1'b1;
      end
    end
  end

  assign upd = (|deq) | (|enq_vld) | wake_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_vld <= '0;
      q_rdy <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        q_cls[i] <= CLS_FAST;
        q_tag[i] <= '0;
      end
    end else if (upd) begin
      q_vld <= n_vld;
      q_rdy <= n_rdy;
      count <= wr;
      for (int i = 0; i < DEPTH; i++) begin
        q_cls[i] <= n_cls[i];
        q_tag[i] <= n_tag[i];
      end
    end
  end

  // R8
  occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEPTH_C);

  // R8
  count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(q_vld) == int'(count));

endmodule

// File: rtl/uop_pick.sv
module uop_pick
  import uop_sched_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAG_W = 6
) (
  input  logic [DEPTH-1:0] q_vld,
  input  logic [DEPTH-1:0] q_rdy,
  input  ucls_e            q_cls [DEPTH],
  input  logic [TAG_W-1:0] q_tag [DEPTH],
  input  logic [NCLS-1:0]  allow,
  input  logic [DEPTH-1:0] excl,
  output logic [DEPTH-1:0] grant,
  output logic             found,
  output ucls_e            g_cls,
  output logic [TAG_W-1:0] g_tag
);

  logic [DEPTH-1:0] cand;
  logic [CLS_W-1:0] cls_acc;

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      cand[i] = q_vld[i] & q_rdy[i] & allow[q_cls[i]] & ~excl[i];
    grant   = cand & (~cand + 1'b1);
    found   = |cand;
    cls_acc = '0;
    g_tag   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (grant[i]) begin
        cls_acc = cls_acc | q_cls[i];
        g_tag   = g_tag | q_tag[i];
      end
    end
    g_cls = ucls_e'(cls_acc);
  end

endmodule

// File: rtl/dual_uop_scheduler.sv
module dual_uop_scheduler
  import uop_sched_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int TAG_W      = 6,
  parameter int NIN        = 3,
  parameter int WB_PER_CLK = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NIN-1:0]           in_vld,
  input  logic [NIN-1:0]           in_rdy,
  input  logic [NIN*CLS_W-1:0]     in_cls,
  input  logic [NIN*TAG_W-1:0]     in_tag,
  output logic                     in_accept,
  input  logic                     wake_vld,
  input  logic [TAG_W-1:0]         wake_tag,
  output logic [NSLOT-1:0]         iss_vld,
  output logic [NSLOT*CLS_W-1:0]   iss_cls,
  output logic [NSLOT*TAG_W-1:0]   iss_tag
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic rst_meta, rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_s, rst_meta} <= 2'b00;
    else        {rst_s, rst_meta} <= {rst_meta, 1'b1};
  end

  ucls_e            u_cls [NIN];
  logic [TAG_W-1:0] u_tag [NIN];
  logic [NIN-1:0]   is_mem, i_enq, m_enq;
  logic [CNT_W-1:0] n_int, n_mem, int_cnt, mem_cnt;

  always_comb begin
    n_int = '0;
    n_mem = '0;
    for (int j = 0; j < NIN; j++) begin
      u_cls[j]  = ucls_e'(in_cls[j*CLS_W +: CLS_W]);
      u_tag[j]  = in_tag[j*TAG_W +: TAG_W];
      is_mem[j] = (u_cls[j] == CLS_LOAD) || (u_cls[j] == CLS_STORE);
      if (in_vld[j]) begin
        if (is_mem[j]) n_mem = n_mem + 1'b1;
        else           n_int = n_int + 1'b1;
      end
    end
    in_accept = (n_int <= DEPTH_C - int_cnt) && (n_mem <= DEPTH_C - mem_cnt);
    i_enq = in_vld & ~is_mem & {NIN{in_accept}};
    m_enq = in_vld &  is_mem & {NIN{in_accept}};
  end

  logic [DEPTH-1:0] iq_vld, iq_rdy, mq_vld, mq_rdy, i_deq, m_deq;
  ucls_e            iq_cls [DEPTH];
  ucls_e            mq_cls [DEPTH];
  logic [TAG_W-1:0] iq_tag [DEPTH];
  logic [TAG_W-1:0] mq_tag [DEPTH];

  uop_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W), .NIN(NIN)) u_iq (
    .clk(clk), .rst_n(rst_s), .enq_vld(i_enq), .enq_rdy(in_rdy),
    .enq_cls(u_cls), .enq_tag(u_tag), .deq(i_deq),
    .wake_vld(wake_vld), .wake_tag(wake_tag),
    .q_vld(iq_vld), .q_rdy(iq_rdy), .q_cls(iq_cls), .q_tag(iq_tag),
    .count(int_cnt));

  uop_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W), .NIN(NIN)) u_mq (
    .clk(clk), .rst_n(rst_s), .enq_vld(m_enq), .enq_rdy(in_rdy),
    .enq_cls(u_cls), .enq_tag(u_tag), .deq(m_deq),
    .wake_vld(wake_vld), .wake_tag(wake_tag),
    .q_vld(mq_vld), .q_rdy(mq_rdy), .q_cls(mq_cls), .q_tag(mq_tag),
    .count(mem_cnt));

  logic [DEPTH-1:0] grant [NSLOT];
  logic [DEPTH-1:0] iexcl [NALU_S+1];
  logic [NSLOT-1:0] found, keep;
  ucls_e            s_cls [NSLOT];
  logic [TAG_W-1:0] s_tag [NSLOT];

  assign iexcl[0] = '0;

  generate
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      if (s < NALU_S) begin : g_alu
        uop_pick #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_pick (
          .q_vld(iq_vld), .q_rdy(iq_rdy), .q_cls(iq_cls), .q_tag(iq_tag),
          .allow(slot_allow(s)), .excl(iexcl[s]), .grant(grant[s]),
          .found(found[s]), .g_cls(s_cls[s]), .g_tag(s_tag[s]));
        assign iexcl[s+1] = iexcl[s] | grant[s];
      end else begin : g_mem
        uop_pick #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_pick (
          .q_vld(mq_vld), .q_rdy(mq_rdy), .q_cls(mq_cls), .q_tag(mq_tag),
          .allow(slot_allow(s)), .excl('0), .grant(grant[s]),
          .found(found[s]), .g_cls(s_cls[s]), .g_tag(s_tag[s]));
      end
    end
  endgenerate

  // writeback budget: earliest slots win, the rest stay queued
  always_comb begin
    int used;
    used  = 0;
    keep  = '0;
    i_deq = '0;
    m_deq = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (found[s] && used < WB_PER_CLK) begin
        keep[s] = 1'b1;
        used    = used + 1;
        if (s < NALU_S) i_deq = i_deq | grant[s];
        else            m_deq = m_deq | grant[s];
      end
    end
    for (int s = 0; s < NSLOT; s++) begin
      iss_cls[s*CLS_W +: CLS_W] = keep[s] ? s_cls[s] : '0;
      iss_tag[s*TAG_W +: TAG_W] = keep[s] ? s_tag[s] : '0;
    end
    iss_vld = keep;
  end

  // R7
  wb_cap_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $countones(iss_vld) <= WB_PER_CLK);

  // R2
  p0_late_fast_chk: assert property (@(posedge clk) disable iff (!rst_s)
    iss_vld[2] |-> (iss_cls[2*CLS_W +: CLS_W] == CLS_FAST));

  // R3
  p1_late_fast_chk: assert property (@(posedge clk) disable iff (!rst_s)
    iss_vld[3] |-> (iss_cls[3*CLS_W +: CLS_W] == CLS_FAST));

  // R5
  p0_first_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (iss_vld[1] && iss_cls[1*CLS_W +: CLS_W] == CLS_FAST) |-> iss_vld[0]);

  // R6
  ld_port_chk: assert property (@(posedge clk) disable iff (!rst_s)
    iss_vld[4] |-> (iss_cls[4*CLS_W +: CLS_W] == CLS_LOAD));

  // R6
  st_port_chk: assert property (@(posedge clk) disable iff (!rst_s)
    iss_vld[5] |-> (iss_cls[5*CLS_W +: CLS_W] == CLS_STORE));

endmodule

// File: tb/dual_uop_scheduler_test.sv
module dual_uop_scheduler_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  in_vld, in_rdy;
  logic [8:0]  in_cls;
  logic [17:0] in_tag;
  logic        in_accept, wake_vld;
  logic [5:0]  wake_tag, iss_vld;
  logic [17:0] iss_cls;
  logic [35:0] iss_tag;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dual_uop_scheduler uut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_rdy(in_rdy),
    .in_cls(in_cls), .in_tag(in_tag), .in_accept(in_accept),
    .wake_vld(wake_vld), .wake_tag(wake_tag), .iss_vld(iss_vld),
    .iss_cls(iss_cls), .iss_tag(iss_tag));

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic slot(input string req, input int s,
                      input logic [2:0] c, input logic [5:0] t);
    chk(req, $sformatf("slot%0d class", s), 32'(iss_cls[s*3 +: 3]), 32'(c));
    chk(req, $sformatf("slot%0d tag", s),   32'(iss_tag[s*6 +: 6]), 32'(t));
  endtask

  task automatic put(input int j, input logic [2:0] c, input logic r,
                     input logic [5:0] t);
    in_vld[j]         = 1'b1;
    in_rdy[j]         = r;
    in_cls[j*3 +: 3]  = c;
    in_tag[j*6 +: 6]  = t;
  endtask

  task automatic clr();
    in_vld = '0; in_rdy = '0; in_cls = '0; in_tag = '0;
    wake_vld = 1'b0; wake_tag = '0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10", "in_accept", 32'(in_accept), 32'd1);
    chk("R10", "iss_vld", 32'(iss_vld), 32'd0);
  endtask

  task automatic t_single();
    put(0, 3'd0, 1'b1, 6'd1);
    step(); clr();
    chk("R1", "iss_vld", 32'(iss_vld), 32'b000001);
    slot("R2", 0, 3'd0, 6'd1);
    step();
    chk("R1", "drained", 32'(iss_vld), 32'd0);
  endtask

  task automatic t_three_fast();
    put(0, 3'd0, 1'b1, 6'd2); put(1, 3'd0, 1'b1, 6'd3); put(2, 3'd0, 1'b1, 6'd4);
    step(); clr();
    chk("R5", "iss_vld", 32'(iss_vld), 32'b000111);
    slot("R5", 0, 3'd0, 6'd2);
    slot("R3", 1, 3'd0, 6'd3);
    slot("R2", 2, 3'd0, 6'd4);
    step();
    chk("R5", "drained", 32'(iss_vld), 32'd0);
  endtask

  task automatic t_binding();
    put(0, 3'd2, 1'b1, 6'd5); put(1, 3'd3, 1'b1, 6'd6); put(2, 3'd1, 1'b1, 6'd7);
    step(); clr();
    chk("R2", "iss_vld early only", 32'(iss_vld), 32'b000011);
    slot("R2", 0, 3'd2, 6'd5);
    slot("R3", 1, 3'd3, 6'd6);
    step();
    chk("R3", "shift waits for early slot", 32'(iss_vld), 32'b000010);
    slot("R3", 1, 3'd1, 6'd7);
    step();
    chk("R3", "drained", 32'(iss_vld), 32'd0);
  endtask

  task automatic t_age_wake();
    put(0, 3'd0, 1'b0, 6'd8); put(1, 3'd0, 1'b1, 6'd9);
    step(); clr();
    chk("R9", "iss_vld", 32'(iss_vld), 32'b000001);
    slot("R4", 0, 3'd0, 6'd9);
    step();
    chk("R9", "unwoken stays", 32'(iss_vld), 32'd0);
    wake_vld = 1'b1; wake_tag = 6'd8;
    step(); clr();
    chk("R9", "woken issues", 32'(iss_vld), 32'b000001);
    slot("R4", 0, 3'd0, 6'd8);
    step();
    chk("R9", "drained", 32'(iss_vld), 32'd0);
  endtask

  task automatic t_mem();
    put(0, 3'd4, 1'b1, 6'd10); put(1, 3'd4, 1'b1, 6'd11); put(2, 3'd5, 1'b1, 6'd12);
    step(); clr();
    chk("R6", "iss_vld", 32'(iss_vld), 32'b110000);
    slot("R6", 4, 3'd4, 6'd10);
    slot("R6", 5, 3'd5, 6'd12);
    step();
    chk("R6", "second load", 32'(iss_vld), 32'b010000);
    slot("R6", 4, 3'd4, 6'd11);
    step();
    chk("R1", "drained", 32'(iss_vld), 32'd0);
  endtask

  task automatic t_cap();
    for (int j = 0; j < 3; j++) put(j, 3'd0, 1'b0, 6'd20);
    step(); clr();
    put(0, 3'd0, 1'b0, 6'd20); put(1, 3'd4, 1'b0, 6'd20);
    step(); clr();
    chk("R9", "nothing ready", 32'(iss_vld), 32'd0);
    wake_vld = 1'b1; wake_tag = 6'd20;
    step(); clr();
    chk("R7", "cap first clock", 32'(iss_vld), 32'b000111);
    step();
    chk("R7", "leftovers", 32'(iss_vld), 32'b010001);
    step();
    chk("R7", "drained", 32'(iss_vld), 32'd0);
  endtask

  task automatic t_full();
    for (int j = 0; j < 3; j++) put(j, 3'd0, 1'b0, 6'd30);
    step(); clr();
    for (int j = 0; j < 3; j++) put(j, 3'd0, 1'b0, 6'd30);
    step(); clr();
    put(0, 3'd0, 1'b0, 6'd30); put(1, 3'd0, 1'b0, 6'd30);
    step(); clr();
    put(0, 3'd0, 1'b1, 6'd32);
    #1 chk("R8", "full rejects", 32'(in_accept), 32'd0);
    step(); clr();
    put(0, 3'd0, 1'b1, 6'd32); put(1, 3'd4, 1'b1, 6'd33);
    #1 chk("R8", "mixed all-or-nothing", 32'(in_accept), 32'd0);
    step(); clr();
    chk("R8", "rejected never issues", 32'(iss_vld), 32'd0);
    put(0, 3'd4, 1'b1, 6'd31);
    #1 chk("R8", "memory room", 32'(in_accept), 32'd1);
    step(); clr();
    chk("R8", "load accepted", 32'(iss_vld), 32'b010000);
    slot("R8", 4, 3'd4, 6'd31);
    wake_vld = 1'b1; wake_tag = 6'd30;
    step(); clr();
    chk("R7", "drain 1", 32'(iss_vld), 32'b000111);
    step();
    chk("R7", "drain 2", 32'(iss_vld), 32'b000111);
    step();
    chk("R8", "drain 3", 32'(iss_vld), 32'b000011);
    step();
    chk("R8", "exactly eight held", 32'(iss_vld), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    clr();
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
    t_reset();
    t_single();
    t_three_fast();
    t_binding();
    t_age_wake();
    t_mem();
    t_cap();
    t_full();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule